// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Thresholds

This block is a first-in first-out buffer for 9-bit words, written on one clock and read on another. The depth is a power-of-two parameter. Supported depths include 64, 256, 512, 1024, 2048 and 4096. Four active-low status flags report the fill level:

- Full and almost-full are registered on the write clock.
- Empty and almost-empty are registered on the read clock.

Each pointer is one bit wider than the address. Each pointer crosses to the other domain as Gray code through a two-flop synchronizer. A flag therefore asserts on the edge of the operation that causes it. It deasserts a few cycles later, once the far pointer has crossed.

Two offset registers set the thresholds:

- The empty offset n sets the almost-empty threshold.
- The full offset m sets the almost-full threshold.

Both offsets load through a strobe on the write clock, with a select bit. A load is taken only while the write side sees the FIFO empty. The offsets therefore change only while the read side cannot be using them.

Top module: `dc_fifo_thr`

## Requirements
- R1: Words written with wr_en_i come out of rdata_o in write order with all 9 bits intact. rdata_o updates on the first read-clock edge that accepts a read and holds otherwise.
- R2: After reset with no reads, full_no goes low on exactly the DEPTH-th accepted write. A write attempted while full_no is low is ignored: it stores nothing and moves no pointer.
- R3: empty_no is low exactly when the read pointer equals the write pointer. A read attempted while empty_no is low is ignored, and rdata_o keeps its value.
- R4: Once settled, afull_no is low when the word count is DEPTH−m or more, and high otherwise.
- R5: Once settled, aempty_no is low when the word count is n or fewer, including zero. It is high from n+1 words up to DEPTH.
- R6: Asynchronous reset rst_ni clears both pointers, drives empty_no and aempty_no low and full_no and afull_no high, and sets both offsets to 7.
- R7: A cfg_ld_i pulse on the write clock loads cfg_val_i into the empty offset when cfg_sel_i=0, or into the full offset when cfg_sel_i=1. The pulse is taken only while the FIFO is empty. A value of 0 is stored as 1, so each offset stays within 1 to DEPTH−1.
- R8: full_no and afull_no change only on write-clock edges, and empty_no and aempty_no only on read-clock edges. Full goes low at the edge of the write that fills the FIFO. Empty goes low at the edge of the read that drains it.
- R9: Reads and writes issued at the same time, including near empty and near full, lose, duplicate and corrupt no word. After settling, the flags match the true count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Write request, write clock |
| wdata_i | input | 9 | Write data |
| rd_en_i | input | 1 | Read request, read clock |
| rdata_o | output | 9 | Registered read data |
| cfg_ld_i | input | 1 | Offset load strobe, write clock |
| cfg_sel_i | input | 1 | 0 selects empty offset, 1 selects full offset |
| cfg_val_i | input | log2(DEPTH) | Offset value to load |
| full_no | output | 1 | Full, active low, write clock |
| afull_no | output | 1 | Almost-full, active low, write clock |
| empty_no | output | 1 | Empty, active low, read clock |
| aempty_no | output | 1 | Almost-empty, active low, read clock |

## Verification
The internal pointers and offsets are observable only through the flags and the read data. A damaged pointer shows up as a flag that disagrees with the bench's own word count once both sides have settled, about eight cycles on each side. It also shows up as a word out of order on the next accepted read. A wrong offset or a wrongly accepted load moves the threshold of an almost flag by at least one word. The level sweep across each threshold exposes this at the first level past the boundary. Lost or duplicated words under concurrent traffic appear as a scoreboard mismatch on the first read that follows the fault.

// File: rtl/dc_fifo_pkg.sv
package dc_fifo_pkg;
  typedef enum logic {
    OFS_EMPTY = 1'b0,
    OFS_FULL  = 1'b1
  } ofs_sel_e;

  localparam int DEF_OFS = 7;
endpackage

// File: rtl/dc_fifo_sync.sv
module dc_fifo_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dc_fifo_wr_ctl.sv
module dc_fifo_wr_ctl
  import dc_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW:0]   rgray_s_i,
  input  logic          cfg_ld_i,
  input  logic          cfg_sel_i,
  input  logic [AW-1:0] cfg_val_i,
  output logic          wr_go_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic [AW-1:0] ae_ofs_o,
  output logic          full_no,
  output logic          afull_no
);
  localparam logic [AW:0]   DEPTH_W = DEPTH[AW:0];
  localparam logic [AW-1:0] OFS_RST = DEF_OFS[AW-1:0];

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0]   wbin_q, wbin_nx, rbin_s, wcnt_nx;
  logic [AW-1:0] af_ofs_q, ae_ofs_q, ofs_val;
  logic          cfg_go;
  ofs_sel_e      sel;

  assign wr_go_o = wr_en_i & full_no;
  assign wbin_nx = wbin_q + {{AW{1'b0}}, wr_go_o};
  assign rbin_s  = g2b(rgray_s_i);
  assign wcnt_nx = wbin_nx - rbin_s;
  assign waddr_o = wbin_q[AW-1:0];
  assign ae_ofs_o = ae_ofs_q;

  // Offsets only change while the write side sees the FIFO empty.
  assign cfg_go  = cfg_ld_i & (wbin_q == rbin_s);
  assign ofs_val = (cfg_val_i == '0) ? AW'(1) : cfg_val_i;
  assign sel     = ofs_sel_e'(cfg_sel_i);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q   <= '0;
      wgray_o  <= '0;
      full_no  <= 1'b1;
      afull_no <= 1'b1;
    end else begin
      wbin_q   <= wbin_nx;
      wgray_o  <= wbin_nx ^ (wbin_nx >> 1);
      full_no  <= !(wcnt_nx == DEPTH_W);
      afull_no <= !(wcnt_nx >= (DEPTH_W - {1'b0, af_ofs_q}));
    end
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_ofs_q <= OFS_RST;
      af_ofs_q <= OFS_RST;
    end else if (cfg_go) begin
      if (sel == OFS_FULL) af_ofs_q <= ofs_val;
      else                 ae_ofs_q <= ofs_val;
    end
  end

  p_no_overflow_r2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!full_no && wr_en_i) |=> $stable(wbin_q));
  p_full_in_afull_r4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> !afull_no);
  p_ofs_range_r7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (ae_ofs_q != '0) && (af_ofs_q != '0));
  p_gray_step_r9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wr_go_o |=> ($countones(wgray_o ^ $past(wgray_o)) == 1));
endmodule

// File: rtl/dc_fifo_rd_ctl.sv
module dc_fifo_rd_ctl #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW:0]   wgray_s_i,
  input  logic [AW-1:0] ae_ofs_i,
  output logic          rd_go_o,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic          empty_no,
  output logic          aempty_no
);
  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] rbin_q, rbin_nx, wbin_s, rcnt_nx;

  assign rd_go_o = rd_en_i & empty_no;
  assign rbin_nx = rbin_q + {{AW{1'b0}}, rd_go_o};
  assign wbin_s  = g2b(wgray_s_i);
  assign rcnt_nx = wbin_s - rbin_nx;
  assign raddr_o = rbin_q[AW-1:0];

  // ae_ofs_i is quasi-static: it only changes while nothing is stored.
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q    <= '0;
      rgray_o   <= '0;
      empty_no  <= 1'b0;
      aempty_no <= 1'b0;
    end else begin
      rbin_q    <= rbin_nx;
      rgray_o   <= rbin_nx ^ (rbin_nx >> 1);
      empty_no  <= !(rcnt_nx == '0);
      aempty_no <= !(rcnt_nx <= {1'b0, ae_ofs_i});
    end
  end

  p_no_underflow_r3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!empty_no && rd_en_i) |=> $stable(rbin_q));
  p_empty_in_aempty_r5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |-> !aempty_no);
  p_rgray_step_r9: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_go_o |=> ($countones(rgray_o ^ $past(rgray_o)) == 1));
endmodule

// File: rtl/dc_fifo_thr.sv
module dc_fifo_thr #(
  parameter int DEPTH  = 64,
  parameter int DW     = 9,
  parameter int STAGES = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o,
  input  logic          cfg_ld_i,
  input  logic          cfg_sel_i,
  input  logic [AW-1:0] cfg_val_i,
  output logic          full_no,
  output logic          afull_no,
  output logic          empty_no,
  output logic          aempty_no
);
  logic [DW-1:0] mem_q [DEPTH];
  logic          wr_go, rd_go;
  logic [AW-1:0] waddr, raddr, ae_ofs;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;

  dc_fifo_wr_ctl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .wclk_i, .rst_ni, .wr_en_i, .rgray_s_i(rgray_s),
    .cfg_ld_i, .cfg_sel_i, .cfg_val_i,
    .wr_go_o(wr_go), .waddr_o(waddr), .wgray_o(wgray), .ae_ofs_o(ae_ofs),
    .full_no, .afull_no
  );

  dc_fifo_rd_ctl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
    .rclk_i, .rst_ni, .rd_en_i, .wgray_s_i(wgray_s), .ae_ofs_i(ae_ofs),
    .rd_go_o(rd_go), .raddr_o(raddr), .rgray_o(rgray),
    .empty_no, .aempty_no
  );

  dc_fifo_sync #(.W(AW+1), .STAGES(STAGES)) u_w2r (
    .clk_i(rclk_i), .rst_ni, .d_i(wgray), .q_o(wgray_s)
  );

  dc_fifo_sync #(.W(AW+1), .STAGES(STAGES)) u_r2w (
    .clk_i(wclk_i), .rst_ni, .d_i(rgray), .q_o(rgray_s)
  );

  always_ff @(posedge wclk_i) begin
    if (wr_go) mem_q[waddr] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_go) rdata_o <= mem_q[raddr];
  end

  p_rdata_hold_r3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !(rd_en_i && empty_no) |=> $stable(rdata_o));
endmodule

// File: tb/sim_dc_fifo_thr.sv
module sim_dc_fifo_thr;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);
  localparam int NLV   = 14;
  // target fill levels walked with default offsets (n = m = 7)
  localparam int LV [NLV] = '{0, 1, 6, 7, 8, 30, 56, 57, 58, 63, 64, 40, 7, 0};

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, cfg_ld = 0, cfg_sel = 0;
  logic [8:0] wdata = '0;
  logic [8:0] rdata;
  logic [AW-1:0] cfg_val = '0;
  logic full_n, afull_n, empty_n, aempty_n;

  int checks = 0, errors = 0;
  int cnt = 0, n_m = 7, m_m = 7;
  int head = 0, tail = 0;
  logic [8:0] sb [8192];
  logic [8:0] nxt = 9'h1A5;

  always #2 wclk = ~wclk;   // 250 MHz write clock
  always #3 rclk = ~rclk;   // read clock, unrelated period

  dc_fifo_thr #(.DEPTH(DEPTH)) u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata),
    .cfg_ld_i(cfg_ld), .cfg_sel_i(cfg_sel), .cfg_val_i(cfg_val),
    .full_no(full_n), .afull_no(afull_n), .empty_no(empty_n), .aempty_no(aempty_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_one();
    bit acc;
    @(negedge wclk);
    wr_en = 1; wdata = nxt;
    acc = full_n;
    @(posedge wclk);
    @(negedge wclk);
    wr_en = 0;
    if (acc) begin
      sb[tail % 8192] = nxt; tail++; cnt++;
      nxt = nxt * 9'd5 + 9'd3;
    end
  endtask

  task automatic read_one();
    bit acc;
    @(negedge rclk);
    rd_en = 1;
    acc = empty_n;
    @(posedge rclk);
    @(negedge rclk);
    rd_en = 0;
    if (acc) begin
      chk(rdata == sb[head % 8192], "R1 data order", int'(rdata), int'(sb[head % 8192]));
      head++; cnt--;
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge rclk);
    repeat (8) @(posedge wclk);
    @(negedge wclk);
  endtask

  task automatic chk_flags(input string tag);
    chk(full_n  == !(cnt == DEPTH),      {tag, " R2 full"},      int'(full_n),  int'(!(cnt == DEPTH)));
    chk(empty_n == !(cnt == 0),          {tag, " R3 empty"},     int'(empty_n), int'(!(cnt == 0)));
    chk(afull_n == !(cnt >= DEPTH - m_m), {tag, " R4 almost-full"}, int'(afull_n), int'(!(cnt >= DEPTH - m_m)));
    chk(aempty_n == !(cnt <= n_m),       {tag, " R5 almost-empty"}, int'(aempty_n), int'(!(cnt <= n_m)));
  endtask

  task automatic set_level(input int t);
    while (cnt < t) write_one();
    while (cnt > t) read_one();
    settle();
  endtask

  task automatic load_ofs(input bit sel, input int v);
    @(negedge wclk);
    cfg_ld = 1; cfg_sel = sel; cfg_val = v[AW-1:0];
    @(posedge wclk);
    @(negedge wclk);
    cfg_ld = 0;
    if (cnt == 0) begin   // R7 model: accepted only while empty, 0 stored as 1
      if (sel) m_m = (v == 0) ? 1 : v;
      else     n_m = (v == 0) ? 1 : v;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] held;
    #11 rst_n = 1;
    settle();
    // R6 reset state
    chk(full_n == 1 && afull_n == 1, "R6 write flags at reset", int'({full_n, afull_n}), 3);
    chk(empty_n == 0 && aempty_n == 0, "R6 read flags at reset", int'({empty_n, aempty_n}), 0);

    // table walk with default offsets (R6 defaults, R4, R5)
    for (int i = 0; i < NLV; i++) begin
      set_level(LV[i]);
      chk_flags($sformatf("lvl%0d", LV[i]));
    end

    // R8 immediate full on the filling write edge
    set_level(DEPTH - 1);
    write_one();
    chk(full_n == 0, "R8 full on filling edge", int'(full_n), 0);
    chk(afull_n == 0, "R8 almost-full low at full", int'(afull_n), 0);
    // R2 write while full is ignored
    write_one();
    settle();
    chk(cnt == DEPTH && full_n == 0, "R2 write while full", int'(full_n), 0);
    set_level(1);                 // drains through scoreboard: no extra word
    read_one();
    chk(empty_n == 0, "R8 empty on draining edge", int'(empty_n), 0);
    chk(aempty_n == 0, "R8 almost-empty low at empty", int'(aempty_n), 0);

    // R3 read while empty is ignored, rdata holds
    settle();
    held = rdata;
    read_one();
    chk(rdata == held, "R3 rdata hold on empty read", int'(rdata), int'(held));
    chk(empty_n == 0, "R3 still empty", int'(empty_n), 0);
    set_level(1);
    set_level(0);

    // R7 offset loading
    load_ofs(1'b0, 3);
    load_ofs(1'b1, 10);
    set_level(3);  chk_flags("R7 n=3 at 3");
    set_level(4);  chk_flags("R7 n=3 at 4");
    load_ofs(1'b0, 20);           // not empty: ignored
    chk(n_m == 3, "R7 load ignored when not empty", n_m, 3);
    set_level(4);  chk_flags("R7 after ignored load");
    set_level(53); chk_flags("R7 m=10 at 53");
    set_level(54); chk_flags("R7 m=10 at 54");
    set_level(0);
    load_ofs(1'b0, 0);            // stored as 1
    set_level(1);  chk_flags("R7 zero offset at 1");
    set_level(2);  chk_flags("R7 zero offset at 2");
    set_level(0);
    load_ofs(1'b0, 7);
    load_ofs(1'b1, 7);

    // R9 concurrent traffic near empty and near full
    fork
      for (int k = 0; k < 40; k++) write_one();
      for (int k = 0; k < 40; k++) read_one();
    join
    settle();
    chk_flags("R9 concurrent near empty");
    set_level(DEPTH - 2);
    fork
      for (int k = 0; k < 30; k++) write_one();
      for (int k = 0; k < 25; k++) read_one();
    join
    settle();
    chk_flags("R9 concurrent near full");
    set_level(0);
    chk_flags("R9 drained");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule